// File: doc/BRIEF.md
# Row-Buffered DRAM Array Model

This block is a synthesizable model of a small DRAM-style storage grid. Every byte sits at a (row, column) position, and an access always takes two steps over one shared address bus. A row strobe opens a row: the whole row is copied into an internal row buffer. Column strobes that follow then read or write single bytes in that buffer. The array itself changes only when the buffer is written back, which happens when a different row (or the same row again) is opened, or when the open row is closed.

A column read returns its byte on a valid/ready response channel. The response is a single-entry register. `rsp_valid` rises one cycle after the read is accepted. It stays high, with `rsp_data` held steady, until a cycle in which `rsp_ready` is high. The block applies back-pressure through `cmd_ready`, which is high when the response register is empty or is being drained in the same cycle. A column operation (read or write) is accepted only in a cycle where `cmd_ready` is high. Row strobes and closes do not depend on `cmd_ready`.

Top module: `rowbuf_dram`

## Requirements
- R1: After reset, `rsp_valid` is low, no row is open and every cell of the array reads as 0x00.
- R2: A row strobe takes the row index from the low ROW_AW bits of `addr`. A column read (`col_write`=0) that follows returns the byte at (that row, column), where the column index is the low COL_AW bits of `addr`.
- R3: When a column read is accepted at a clock edge, `rsp_valid` is high after that edge with the addressed byte. If `rsp_ready` is high, `rsp_valid` falls after the next edge unless another read is accepted at that edge.
- R4: A column strobe while no row is open is ignored. It produces no response, and it changes no cell.
- R5: A column write (`col_write`=1) replaces the addressed byte in the row buffer with `wdata`. A later read of the same open row returns the new byte, without the row being reopened.
- R6: A row strobe while a row is open first writes the buffer back to the array. Bytes written earlier survive a switch to another row and are returned when their row is opened again.
- R7: `close_row` writes the buffer back and leaves no row open. Column strobes after a close are ignored until the next row strobe.
- R8: A row strobe takes priority over `close_row`, and both take priority over `col_strobe`. A column strobe in the same cycle as either one is ignored.
- R9: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid` and `rsp_data` hold their values and `cmd_ready` is low. Column strobes in that state are ignored.
- R10: A row strobe that reopens the row that is already open keeps every byte written into the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | ADDR_W | Shared row/column address |
| row_strobe | input | 1 | Open the row given on `addr` |
| col_strobe | input | 1 | Column access at the column given on `addr` |
| col_write | input | 1 | With `col_strobe`: 1 selects a write, 0 a read |
| wdata | input | 8 | Byte to write |
| close_row | input | 1 | Write back and close the open row |
| cmd_ready | output | 1 | A column operation can be accepted this cycle |
| rsp_valid | output | 1 | Read response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_data | output | 8 | Read byte |

## Verification
Each command takes effect at the clock edge that samples it, and a read's byte is due on `rsp_valid`/`rsp_data` just after that same edge. The bench samples at every falling edge, half a cycle after the result registers change. A behavioural model holds the grid, the buffer and the pending response. It is stepped once per rising edge from the inputs driven at the previous falling edge. Every falling edge then compares `cmd_ready`, `rsp_valid` and, when a response is present, `rsp_data`. This makes any early, late or missing response, or any lost write-back, show up as a mismatch in the exact cycle where it occurs.

// File: rtl/rbd_pkg.sv
package rbd_pkg;
  localparam int CELL_W = 8;
  typedef logic [CELL_W-1:0] cell_t;
endpackage

// File: rtl/rbd_cell_array.sv
module rbd_cell_array
  import rbd_pkg::*;
#(
  parameter int ROW_AW = 4,
  parameter int COL_AW = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [ROW_AW-1:0]             rd_idx,
  output logic [(1<<COL_AW)*CELL_W-1:0] rd_row,
  input  logic                          wr_en,
  input  logic [ROW_AW-1:0]             wr_idx,
  input  logic [(1<<COL_AW)*CELL_W-1:0] wr_row
);
  localparam int ROWS  = 1 << ROW_AW;
  localparam int ROW_W = (1 << COL_AW) * CELL_W;

  logic [ROW_W-1:0] grid [ROWS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++) grid[r] <= '0;
    end else if (wr_en) begin
      grid[wr_idx] <= wr_row;
    end
  end

  assign rd_row = grid[rd_idx];
endmodule

// File: rtl/rbd_row_buffer.sv
module rbd_row_buffer
  import rbd_pkg::*;
#(
  parameter int COL_AW = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          load_en,
  input  logic [(1<<COL_AW)*CELL_W-1:0] load_row,
  input  logic                          wr_en,
  input  logic [COL_AW-1:0]             col_idx,
  input  cell_t                         wr_data,
  output logic [(1<<COL_AW)*CELL_W-1:0] row_flat,
  output cell_t                         rd_data
);
  localparam int COLS = 1 << COL_AW;

  cell_t slot [COLS];

  genvar g;
  generate
    for (g = 0; g < COLS; g++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          slot[g] <= '0;
        else if (load_en)
          slot[g] <= load_row[g*CELL_W +: CELL_W];
        else if (wr_en && (col_idx == COL_AW'(g)))
          slot[g] <= wr_data;
      end
      assign row_flat[g*CELL_W +: CELL_W] = slot[g];
    end
  endgenerate

  assign rd_data = slot[col_idx];
endmodule

// File: rtl/rbd_seq.sv
module rbd_seq #(
  parameter int ROW_AW = 4,
  parameter int COL_AW = 4,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              row_strobe,
  input  logic              col_strobe,
  input  logic              col_write,
  input  logic              close_row,
  input  logic              cmd_ready,
  output logic              wb_en,
  output logic [ROW_AW-1:0] wb_idx,
  output logic              load_en,
  output logic [ROW_AW-1:0] load_idx,
  output logic              bypass,
  output logic              col_wr_en,
  output logic              col_rd_en,
  output logic [COL_AW-1:0] col_idx
);
  logic              open_q;
  logic [ROW_AW-1:0] row_q;
  logic              col_take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      row_q  <= '0;
    end else if (row_strobe) begin
      open_q <= 1'b1;
      row_q  <= load_idx;
    end else if (close_row) begin
      open_q <= 1'b0;
    end
  end

  assign load_idx  = addr[ROW_AW-1:0];
  assign col_idx   = addr[COL_AW-1:0];
  assign load_en   = row_strobe;
  assign wb_en     = open_q && (row_strobe || close_row);
  assign wb_idx    = row_q;
  assign bypass    = open_q && (load_idx == row_q);
  assign col_take  = col_strobe && open_q && cmd_ready && !row_strobe && !close_row;
  assign col_wr_en = col_take && col_write;
  assign col_rd_en = col_take && !col_write;
endmodule

// File: rtl/rbd_rsp.sv
module rbd_rsp
  import rbd_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  rd_take,
  input  cell_t rd_data,
  input  logic  rsp_ready,
  output logic  rsp_valid,
  output cell_t rsp_data,
  output logic  cmd_ready
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (rd_take) begin
      rsp_valid <= 1'b1;
      rsp_data  <= rd_data;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  assign cmd_ready = !rsp_valid || rsp_ready;
endmodule

// File: rtl/rowbuf_dram.sv
module rowbuf_dram
  import rbd_pkg::*;
#(
  parameter int ROW_AW = 4,
  parameter int COL_AW = 4,
  localparam int ADDR_W = (ROW_AW > COL_AW) ? ROW_AW : COL_AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              row_strobe,
  input  logic              col_strobe,
  input  logic              col_write,
  input  logic [7:0]        wdata,
  input  logic              close_row,
  output logic              cmd_ready,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [7:0]        rsp_data
);
  localparam int ROW_W = (1 << COL_AW) * CELL_W;

  logic              wb_en, load_en, bypass, col_wr_en, col_rd_en;
  logic [ROW_AW-1:0] wb_idx, load_idx;
  logic [COL_AW-1:0] col_idx;
  logic [ROW_W-1:0]  arr_row, buf_row, load_row;
  cell_t             buf_byte;

  rbd_seq #(.ROW_AW(ROW_AW), .COL_AW(COL_AW), .ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .addr(addr),
    .row_strobe(row_strobe), .col_strobe(col_strobe), .col_write(col_write),
    .close_row(close_row), .cmd_ready(cmd_ready),
    .wb_en(wb_en), .wb_idx(wb_idx), .load_en(load_en), .load_idx(load_idx),
    .bypass(bypass), .col_wr_en(col_wr_en), .col_rd_en(col_rd_en), .col_idx(col_idx)
  );

  rbd_cell_array #(.ROW_AW(ROW_AW), .COL_AW(COL_AW)) u_array (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(load_idx), .rd_row(arr_row),
    .wr_en(wb_en), .wr_idx(wb_idx), .wr_row(buf_row)
  );

  assign load_row = bypass ? buf_row : arr_row;

  rbd_row_buffer #(.COL_AW(COL_AW)) u_buf (
    .clk(clk), .rst_n(rst_n),
    .load_en(load_en), .load_row(load_row),
    .wr_en(col_wr_en), .col_idx(col_idx), .wr_data(wdata),
    .row_flat(buf_row), .rd_data(buf_byte)
  );

  rbd_rsp u_rsp (
    .clk(clk), .rst_n(rst_n),
    .rd_take(col_rd_en), .rd_data(buf_byte), .rsp_ready(rsp_ready),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .cmd_ready(cmd_ready)
  );
endmodule

// File: rtl/rowbuf_dram_chk.sv
module rowbuf_dram_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       row_strobe,
  input logic       col_strobe,
  input logic       col_write,
  input logic       close_row,
  input logic       cmd_ready,
  input logic       rsp_valid,
  input logic       rsp_ready,
  input logic [7:0] rsp_data
);
  logic seen_open;
  logic rd_acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          seen_open <= 1'b0;
    else if (row_strobe) seen_open <= 1'b1;
    else if (close_row)  seen_open <= 1'b0;
  end

  assign rd_acc = col_strobe && !col_write && seen_open && cmd_ready
                  && !row_strobe && !close_row;

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));

  assert_ready_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> cmd_ready);

  assert_read_answers_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc |=> rsp_valid);

  assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_ready && !rd_acc |=> !rsp_valid);

  assert_closed_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    col_strobe && !seen_open && !rsp_valid |=> !rsp_valid);

  assert_priority_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (row_strobe || close_row) && (!rsp_valid || rsp_ready) |=> !rsp_valid);
endmodule

bind rowbuf_dram rowbuf_dram_chk u_chk (
  .clk(clk), .rst_n(rst_n), .row_strobe(row_strobe), .col_strobe(col_strobe),
  .col_write(col_write), .close_row(close_row), .cmd_ready(cmd_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data)
);

// File: tb/tb_rowbuf_dram.sv
`timescale 1ns/1ps
module tb_rowbuf_dram;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] addr = '0;
  logic       row_strobe = 1'b0, col_strobe = 1'b0, col_write = 1'b0, close_row = 1'b0;
  logic [7:0] wdata = '0;
  logic       rsp_ready = 1'b1;
  logic       cmd_ready, rsp_valid;
  logic [7:0] rsp_data;

  always #5 clk = ~clk;

  rowbuf_dram dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .row_strobe(row_strobe),
    .col_strobe(col_strobe), .col_write(col_write), .wdata(wdata),
    .close_row(close_row), .cmd_ready(cmd_ready), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_data(rsp_data)
  );

  int total = 0;
  int bad = 0;
  string tag = "R1";

  int mem [16][16];
  int rbuf [16];
  bit m_open = 0;
  int m_row = 0;
  bit e_valid = 0;
  int e_data = 0;

  task automatic check(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic model_step();
    bit rdy = !e_valid || rsp_ready;
    bit took = 0;
    if (row_strobe) begin
      if (m_open) for (int c = 0; c < 16; c++) mem[m_row][c] = rbuf[c];
      for (int c = 0; c < 16; c++) rbuf[c] = mem[addr][c];
      m_open = 1; m_row = addr;
    end else if (close_row) begin
      if (m_open) for (int c = 0; c < 16; c++) mem[m_row][c] = rbuf[c];
      m_open = 0;
    end else if (col_strobe && m_open && rdy) begin
      if (col_write) rbuf[addr] = wdata;
      else begin took = 1; e_data = rbuf[addr]; end
    end
    if (took) e_valid = 1;
    else if (rsp_ready) e_valid = 0;
  endtask

  task automatic compare();
    check(tag, "cmd_ready", cmd_ready, (!e_valid || rsp_ready));
    check(tag, "rsp_valid", rsp_valid, e_valid);
    if (e_valid && rsp_valid) check(tag, "rsp_data", rsp_data, e_data);
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
    row_strobe = 0; col_strobe = 0; col_write = 0; close_row = 0;
  endtask

  task automatic open_row(int r);
    row_strobe = 1; addr = 4'(r); cyc();
  endtask

  task automatic wr(int c, int d);
    col_strobe = 1; col_write = 1; addr = 4'(c); wdata = 8'(d); cyc();
  endtask

  task automatic rd(int c);
    col_strobe = 1; col_write = 0; addr = 4'(c); cyc();
  endtask

  task automatic close();
    close_row = 1; cyc();
  endtask

  bit done = 0;
  initial begin
    #2000000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int r = 0; r < 16; r++) for (int c = 0; c < 16; c++) mem[r][c] = 0;
    for (int c = 0; c < 16; c++) rbuf[c] = 0;
    repeat (3) @(negedge clk);
    tag = "R1"; compare();
    rst_n = 1;
    cyc(); cyc();

    tag = "R4"; rd(3); rd(4); wr(2, 8'h77); cyc();
    tag = "R1"; open_row(0); rd(2); cyc(); rd(15); cyc();

    tag = "R2"; open_row(9); rd(0); cyc();
    tag = "R5";
    for (int c = 0; c < 16; c++) wr(c, c * 7 + 1);
    for (int c = 15; c >= 0; c--) rd(c);
    cyc();
    tag = "R3"; rd(4); cyc(); cyc(); rd(5); rd(6); cyc();

    tag = "R6"; open_row(5); wr(2, 8'hA5); open_row(9);
    rd(0); rd(13); rd(15); open_row(5); rd(2); cyc();

    tag = "R7"; close(); rd(2); wr(2, 8'h11); cyc(); open_row(5); rd(2); cyc();

    tag = "R8";
    row_strobe = 1; col_strobe = 1; addr = 4'd9; cyc(); cyc();
    close_row = 1; col_strobe = 1; col_write = 1; addr = 4'd1; wdata = 8'hEE; cyc();
    row_strobe = 1; close_row = 1; addr = 4'd9; cyc(); rd(1); cyc();

    tag = "R10"; open_row(7); wr(1, 8'h3C); open_row(7); rd(1); cyc();

    tag = "R9";
    rsp_ready = 0; rd(1); cyc(); rd(3); wr(1, 8'h55); cyc(); cyc();
    rsp_ready = 1; cyc(); rd(1); cyc();

    tag = "R2";
    for (int i = 0; i < 400; i++) begin
      int k = $urandom_range(0, 9);
      rsp_ready = ($urandom_range(0, 3) != 0);
      addr = 4'($urandom_range(0, 15));
      wdata = 8'($urandom_range(0, 255));
      row_strobe = (k == 0);
      close_row = (k == 1);
      col_strobe = (k >= 2);
      col_write = (k >= 7);
      cyc();
    end
    rsp_ready = 1; cyc(); cyc();

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule